// File: doc/BRIEF.md
# Per-Core Interval Tick Timer Bank

This block holds a row of identical local tick timers, one per processor core. Each timer has two counting stages. A prescaler divides the input clock by a programmable amount and produces a one-cycle tick. A second counter counts those ticks down and raises an interrupt event when it reaches zero. In interval mode the second counter reloads from its buffer and keeps firing. Otherwise it stays at zero after one event until software programs it again.

Software reaches every timer through one flat register bus with single-cycle writes and a combinational read port. Each timer decodes its own 256-byte page. Every write to a buffer or to the control register sets a write-applied flag, which software clears by writing a one to it. The block drives one interrupt line per core.

Top module: `core_tick_bank`

## Requirements
- R1: Timer n answers in the page starting at 0x300 + 0x100*n. Its registers sit at these offsets: tick reload value +0x00, countdown buffer +0x08, control +0x20, event status +0x30, interrupt enable +0x34, write-applied flags +0x40. Reads return the stored value. Any other offset, and any address outside every page, reads as zero. A write into one page leaves every other page unchanged.
- R2: After reset every register of every timer reads zero and every interrupt line is low.
- R3: While control bit 0 (run) is set and the tick reload value is N, the prescaler issues one tick every N+1 clocks. Writing the tick reload value also reloads the prescaler, so the first tick after run is set comes N+1 clocks later.
- R4: A write to the countdown buffer stores bits 30:0. When bit 31 of the written word is set, the same write also loads the live countdown from bits 30:0. When bit 31 is clear, the live countdown keeps its value.
- R5: While control bit 1 (count enable) is set, each tick decrements the live countdown. The tick that takes it from 1 to 0 sets event status bit 0 on the following clock edge.
- R6: With control bit 2 (interval) set, the countdown reloads from the buffer on that event and repeats. With bit 2 clear it holds at zero and raises no further event.
- R7: Clearing control bit 0 freezes both stages. Setting it again resumes counting from the frozen values.
- R8: Writing 1 to event status bit 0 clears it, and writing 0 leaves it set. An event in the same cycle as a clear wins.
- R9: Interrupt line n is high exactly when timer n has event status bit 0 set and interrupt enable bit 0 set.
- R10: Write-applied flag bit 0 is set by a tick reload write, bit 1 by a countdown buffer write, and bit 3 by a control write. Each flag clears when 1 is written to its bit, and bit 2 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | NUM_CORES | One interrupt line per timer |

## Verification
A register write takes effect at the clock edge that samples it. Read data and write-applied flags reflect it from the next cycle on, and a new control value first affects counting in the cycle after that edge. An event lands at the edge of the tick that takes the countdown to zero, so status and the interrupt line rise right after that edge. With run set on edge 0, the interrupt is first seen after edge M*(N+1). The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares every interrupt line on every falling edge, checks directed reads against the model at the same point, and measures the first-event latency directly.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // register offsets inside one timer page
  localparam logic [7:0] OFF_TICK = 8'h00;
  localparam logic [7:0] OFF_ICNT = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [7:0] OFF_IEN  = 8'h34;
  localparam logic [7:0] OFF_WST  = 8'h40;
  // control bits
  localparam int CTRL_RUN = 0;
  localparam int CTRL_CNT = 1;
  localparam int CTRL_RPT = 2;
  // write-applied flag bits
  localparam int WST_TICK = 0;
  localparam int WST_ICNT = 1;
  localparam int WST_CTRL = 3;
  localparam logic [3:0] WST_MASK = 4'b1011;
  // page of timer 0
  localparam int BASE_PAGE = 3;
  localparam int DATA_W = 32;
  localparam int CNT_W  = DATA_W - 1;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [TICK_W-1:0] load_val_i,
  input  logic [TICK_W-1:0] reload_val_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (run_i) cnt_d = tick_o ? reload_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q)); // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !load_i && reload_val_i != '0) |=> !tick_o); // R3
endmodule

// File: rtl/tick_countdown.sv
module tick_countdown #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             repeat_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step    = tick_i && en_i;
    event_o = step && !load_i && (cnt_q == CNT_W'(1));
    cnt_d   = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step) begin
      if (cnt_q <= CNT_W'(1)) cnt_d = repeat_i ? reload_val_i : '0;
      else                    cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_i && cnt_q == '0 && !load_i) |=> (cnt_q == '0)); // R6
  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/tick_unit.sv
module tick_unit
  import tick_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TICK_W = 32,
  parameter int PAGE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PAGE_W = ADDR_W - 8;

  logic              sel;
  logic [7:0]        off;
  logic              wr_tick, wr_icnt, wr_ctrl, wr_stat, wr_ien, wr_wst;
  logic              icnt_load, tick, evt;
  logic [TICK_W-1:0] tbuf_q, tbuf_d;
  logic [CNT_W-1:0]  ibuf_q, ibuf_d;
  logic [2:0]        ctrl_q, ctrl_d;
  logic              stat_q, stat_d, ien_q, ien_d;
  logic [3:0]        wst_q, wst_d;

  always_comb begin
    sel       = (addr_i[ADDR_W-1:8] == PAGE_W'(PAGE));
    off       = addr_i[7:0];
    wr_tick   = wr_i && sel && off == OFF_TICK;
    wr_icnt   = wr_i && sel && off == OFF_ICNT;
    wr_ctrl   = wr_i && sel && off == OFF_CTRL;
    wr_stat   = wr_i && sel && off == OFF_STAT;
    wr_ien    = wr_i && sel && off == OFF_IEN;
    wr_wst    = wr_i && sel && off == OFF_WST;
    icnt_load = wr_icnt && wdata_i[DATA_W-1];
  end

  tick_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl_q[CTRL_RUN]),
    .load_i       (wr_tick),
    .load_val_i   (wdata_i[TICK_W-1:0]),
    .reload_val_i (tbuf_q),
    .tick_o       (tick)
  );

  tick_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .en_i         (ctrl_q[CTRL_CNT]),
    .repeat_i     (ctrl_q[CTRL_RPT]),
    .load_i       (icnt_load),
    .load_val_i   (wdata_i[CNT_W-1:0]),
    .reload_val_i (ibuf_q),
    .event_o      (evt)
  );

  always_comb begin
    tbuf_d = wr_tick ? wdata_i[TICK_W-1:0] : tbuf_q;
    ibuf_d = wr_icnt ? wdata_i[CNT_W-1:0]  : ibuf_q;
    ctrl_d = wr_ctrl ? wdata_i[2:0]        : ctrl_q;
    ien_d  = wr_ien  ? wdata_i[0]          : ien_q;
    stat_d = evt | (stat_q & ~(wr_stat & wdata_i[0]));
    wst_d  = wst_q;
    if (wr_wst) wst_d = wst_q & ~(wdata_i[3:0] & WST_MASK);
    if (wr_tick) wst_d[WST_TICK] = 1'b1;
    if (wr_icnt) wst_d[WST_ICNT] = 1'b1;
    if (wr_ctrl) wst_d[WST_CTRL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q <= '0;
      ibuf_q <= '0;
      ctrl_q <= '0;
      stat_q <= 1'b0;
      ien_q  <= 1'b0;
      wst_q  <= '0;
    end else begin
      tbuf_q <= tbuf_d;
      ibuf_q <= ibuf_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      wst_q  <= wst_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      case (off)
        OFF_TICK: rdata_o = DATA_W'(tbuf_q);
        OFF_ICNT: rdata_o = DATA_W'(ibuf_q);
        OFF_CTRL: rdata_o = DATA_W'(ctrl_q);
        OFF_STAT: rdata_o = DATA_W'(stat_q);
        OFF_IEN:  rdata_o = DATA_W'(ien_q);
        OFF_WST:  rdata_o = DATA_W'(wst_q);
        default:  rdata_o = '0;
      endcase
    end
    irq_o = stat_q & ien_q;
  end

  AST_EVT_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat_q); // R5
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata_i[0] && !evt) |=> !stat_q); // R8
  AST_WST_CTRL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> wst_q[WST_CTRL]); // R10
endmodule

// File: rtl/core_tick_bank.sv
module core_tick_bank
  import tick_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  parameter int TICK_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DATA_W-1:0] unit_rdata [NUM_CORES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_unit
    tick_unit #(
      .ADDR_W (ADDR_W),
      .TICK_W (TICK_W),
      .PAGE   (BASE_PAGE + g)
    ) u_unit (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (unit_rdata[g]),
      .irq_o   (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_CORES; i++) bus_rdata_o |= unit_rdata[i];
  end

  AST_IRQ_NEEDS_RESET_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (irq_o == '0)); // R2
endmodule

// File: tb/core_tick_bank_tb_top.sv
module core_tick_bank_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  core_tick_bank #(.NUM_CORES(NC), .ADDR_W(12), .TICK_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq));

  always #5 clk = ~clk;

  // behavioural reference model
  int unsigned m_tb[NC], m_ib[NC], m_pc[NC], m_ic[NC];
  bit [2:0] m_ct[NC];
  bit       m_st[NC], m_ie[NC];
  bit [3:0] m_ws[NC];

  function automatic bit [31:0] mread(input bit [11:0] a);
    int p = int'(a[11:8]) - 3;
    if (p < 0 || p >= NC) return 0;
    case (a[7:0])
      8'h00: return m_tb[p];
      8'h08: return m_ib[p];
      8'h20: return 32'(m_ct[p]);
      8'h30: return 32'(m_st[p]);
      8'h34: return 32'(m_ie[p]);
      8'h40: return 32'(m_ws[p]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      bit hit, tk, st, ld, ev;
      bit [7:0] o;
      if (!rst_n) begin
        m_tb[c] = 0; m_ib[c] = 0; m_pc[c] = 0; m_ic[c] = 0;
        m_ct[c] = 0; m_st[c] = 0; m_ie[c] = 0; m_ws[c] = 0;
      end else begin
        hit = bus_wr && (int'(bus_addr[11:8]) == c + 3);
        o   = bus_addr[7:0];
        tk  = m_ct[c][0] && m_pc[c] == 0;
        st  = tk && m_ct[c][1];
        ld  = hit && o == 8'h08 && bus_wdata[31];
        ev  = st && !ld && m_ic[c] == 1;
        if (hit && o == 8'h00) m_pc[c] = bus_wdata;
        else if (m_ct[c][0]) m_pc[c] = tk ? m_tb[c] : m_pc[c] - 1;
        if (ld) m_ic[c] = bus_wdata & 32'h7fff_ffff;
        else if (st) m_ic[c] = (m_ic[c] <= 1) ? (m_ct[c][2] ? m_ib[c] : 0) : m_ic[c] - 1;
        if (hit && o == 8'h30 && bus_wdata[0]) m_st[c] = 0;
        if (ev) m_st[c] = 1;
        if (hit && o == 8'h40) m_ws[c] = m_ws[c] & ~(bus_wdata[3:0] & 4'b1011);
        if (hit && o == 8'h00) begin m_tb[c] = bus_wdata; m_ws[c][0] = 1; end
        if (hit && o == 8'h08) begin m_ib[c] = bus_wdata & 32'h7fff_ffff; m_ws[c][1] = 1; end
        if (hit && o == 8'h20) begin m_ct[c] = bus_wdata[2:0]; m_ws[c][3] = 1; end
        if (hit && o == 8'h34) m_ie[c] = bus_wdata[0];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [NC-1:0] m_irq();
    bit [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = m_st[c] & m_ie[c];
    return v;
  endfunction

  // R9: every interrupt line compared with the model on each falling edge
  always @(negedge clk) if (started && !done) chk("R9 irq", 32'(irq), 32'(m_irq()));

  task automatic wr(input int c, input bit [7:0] o, input bit [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 12'((c + 3) * 256) | 12'(o); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string req, input bit [11:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, mread(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    started = 1;
    // R2 reset state
    for (int c = 0; c < NC; c++)
      foreach (tick_pkg_offs[i]) ;
    rd("R2 tick", 12'h300); rd("R2 ctrl", 12'h620); rd("R2 wst", 12'h440);
    chk("R2 reset values", bus_rdata, 0);
    chk("R2 irq", 32'(irq), 0);
    // R1 decode and isolation
    wr(1, 8'h00, 32'h55);
    rd("R1 own page", 12'h400); chk("R1 value", bus_rdata, 32'h55);
    rd("R1 other page", 12'h300); chk("R1 isolation", bus_rdata, 0);
    rd("R1 hole", 12'h410); chk("R1 hole zero", bus_rdata, 0);
    rd("R1 outside", 12'h200); chk("R1 outside zero", bus_rdata, 0);
    // R10 write-applied flags
    rd("R10 tick flag", 12'h440); chk("R10 tick flag", bus_rdata, 32'h1);
    wr(1, 8'h40, 32'hF); rd("R10 clear", 12'h440); chk("R10 cleared", bus_rdata, 0);
    wr(1, 8'h08, 32'h5); wr(1, 8'h20, 32'h0);
    rd("R10 buf+ctrl", 12'h440); chk("R10 buf+ctrl flags", bus_rdata, 32'hA);
    // R3/R5 first event latency: N=2, M=3 -> 9 edges
    wr(0, 8'h34, 1); wr(0, 8'h00, 2); wr(0, 8'h08, 32'h8000_0003);
    wr(0, 8'h20, 3'b111);
    k = 0;
    while (!irq[0] && k < 200) begin @(negedge clk); k++; end
    chk("R3 R5 first event latency", k, 9);
    // R8 write 0 keeps, write 1 clears
    wr(0, 8'h30, 0); rd("R8 write zero", 12'h330);
    wr(0, 8'h30, 1); rd("R8 write one", 12'h330);
    // R6 interval repeats
    k = 0;
    while (!irq[0] && k < 200) begin @(negedge clk); k++; end
    chk("R6 interval repeats", 32'(irq[0]), 1);
    // R7 freeze: clear run, clear status, no event for 40 cycles
    wr(0, 8'h20, 3'b110); wr(0, 8'h30, 1);
    idle(40);
    chk("R7 frozen no irq", 32'(irq[0]), 0);
    wr(0, 8'h20, 3'b111); idle(30);
    chk("R7 resumed", 32'(irq[0]), 32'(m_irq() >> 0) & 1);
    // R6 one-shot on core 2: N=0, M=2
    wr(2, 8'h34, 1); wr(2, 8'h08, 32'h8000_0002); wr(2, 8'h20, 3'b011);
    idle(4);
    chk("R6 one-shot fired", 32'(irq[2]), 1);
    wr(2, 8'h30, 1); idle(20);
    chk("R6 one-shot holds", 32'(irq[2]), 0);
    // R4 buffer write without strobe leaves live countdown at zero
    wr(2, 8'h08, 32'h1); idle(10);
    chk("R4 no strobe no load", 32'(irq[2]), 0);
    wr(2, 8'h08, 32'h8000_0001); idle(3);
    chk("R4 strobe loads", 32'(irq[2]), 1);
    // R9 enable gating
    wr(2, 8'h34, 0);
    chk("R9 gated off", 32'(irq[2]), 0);
    rd("R9 status still set", 12'h530); chk("R9 status", bus_rdata, 1);
    // R5 count enable clear: no event
    wr(3, 8'h34, 1); wr(3, 8'h08, 32'h8000_0001); wr(3, 8'h20, 3'b001);
    idle(10);
    chk("R5 count disabled", 32'(irq[3]), 0);
    idle(20);
    finish_run();
  end

  bit tick_pkg_offs[1];
endmodule